// File: doc/BRIEF.md
# Accumulator Register-File Execution Unit

This block carries out a handful of single-cycle operations for an 8-bit accumulator machine backed by a 64-entry register file. The operations are: zeroing the accumulator, zeroing one register, bitwise inversion of a register with the result steered to the accumulator or written back in place, decimal correction of the accumulator after a binary addition, and a watchdog restart. Decoded operations arrive with an execute strobe, a register address and a destination bit. The accumulator, the status flags and the watchdog and prescaler restart pulses leave the block. A second, read-only register port lets neighbouring logic observe any register.

Each operation changes only its own group of flags. Zeroing operations force the zero flag. Inversion computes the zero flag from its result. Decimal correction touches only the carry flag. The watchdog restart sets the time-out and power-down flags. The watchdog counter and the time-out and sleep logic sit outside the block. Their events reach it as single-cycle inputs that clear the time-out and power-down flags.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset the accumulator and every register hold 00h, zero flag Z and carry flag C are 0, time-out flag TO and power-down flag PD are 1, and both restart pulses are low.
- R2: Operation code 1 (zero accumulator) writes 00h to the accumulator and sets Z to 1. C, TO, PD and the register file are unchanged.
- R3: Operation code 2 (zero register) writes 00h to the addressed register (address 0 to 63) and sets Z to 1. The accumulator and the other registers are unchanged.
- R4: Operation code 3 (invert register) with destination bit 0 writes the bitwise inverse of the addressed register to the accumulator and leaves the register unchanged. Z becomes 1 exactly when the result is 00h.
- R5: Operation code 3 with destination bit 1 writes the inverse back into the addressed register and leaves the accumulator unchanged. Z follows the result as in R4.
- R6: Operation code 4 (decimal adjust) adds 06h to the accumulator when its low nibble exceeds 9 or the half-carry input is 1.
- R7: After the R6 step, decimal adjust also adds 60h when that step carried out of bit 7, when the high nibble exceeds 9, or when C was 1. C becomes 1 when this second correction is applied and 0 when it is not. Z is unchanged.
- R8: Operation code 5 (watchdog restart) sets TO and PD to 1 and pulses the watchdog restart output high for one cycle. The prescaler restart output pulses with it only when the prescaler-assignment input is 1 (assigned to the watchdog).
- R9: A time-out event clears TO and a sleep event clears PD. A watchdog restart in the same cycle takes priority and leaves both flags at 1.
- R10: With the strobe low, or with operation code 0, 6 or 7, the accumulator, the register file and the flags keep their values. TO and PD still follow the R9 events.
- R11: Every operation takes effect at the clock edge that samples the strobe, so its result is visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe for the presented operation |
| op_i | input | 3 | Decoded operation code |
| addr_i | input | 6 | Register address operand |
| dest_i | input | 1 | Destination bit for inversion (0 accumulator, 1 register) |
| half_carry_i | input | 1 | Half-carry recorded by the last addition |
| psc_to_wdt_i | input | 1 | 1 when the prescaler is assigned to the watchdog |
| wdt_timeout_i | input | 1 | Watchdog time-out event, clears TO |
| sleep_i | input | 1 | Sleep entry event, clears PD |
| peek_addr_i | input | 6 | Observation read address |
| acc_o | output | 8 | Accumulator |
| peek_data_o | output | 8 | Register at peek_addr_i |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| to_o | output | 1 | Time-out flag |
| pd_o | output | 1 | Power-down flag |
| wdt_clr_o | output | 1 | One-cycle watchdog restart pulse |
| psc_clr_o | output | 1 | One-cycle prescaler restart pulse |

## Verification
The hardest case to reach is the second stage of decimal adjust. The only values the accumulator can take through this block are 00h, FFh and the results of earlier adjustments. The stimulus starts with an inverted zero register, which gives FFh. It then chains several adjustments with and without the half-carry input. This reaches the carry out of the first stage, the high-nibble correction and the path where the correction is forced only by C. Collisions between a watchdog restart and time-out or sleep events in the same cycle are driven on purpose to check the priority.

// File: rtl/acc_eu_pkg.sv
package acc_eu_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_NOP    = 3'd0,
      OP_CLRA   = 3'd1,
      OP_CLRR   = 3'd2,
      OP_COMR   = 3'd3,
      OP_DAA    = 3'd4,
      OP_CLRWDT = 3'd5
   } op_e;

   localparam logic [3:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/acc_eu_regfile.sv
module acc_eu_regfile #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      if (DATA_W < 1) $error("acc_eu_regfile: DATA_W must be positive");
      if (ADDR_W < 1 || ADDR_W > 10) $error("acc_eu_regfile: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem[gi] <= '0;
            else if (we && waddr == ADDR_W'(gi))    mem[gi] <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && waddr == ADDR_W'(gi))         mem[gi] <= wdata;
         end
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

   // R3/R5: a strobed write lands in the addressed entry by the next cycle
   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/acc_eu_decadj.sv
module acc_eu_decadj
   import acc_eu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc,
   input  logic              half_carry,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);
   localparam int NIB = 4;

   initial begin
      if (DATA_W != 2 * NIB) $error("acc_eu_decadj: needs two nibbles");
   end

   logic          lo_fix, hi_fix;
   logic [DATA_W:0] stage1;

   always_comb begin
      lo_fix    = (acc[NIB-1:0] > BCD_MAX) || half_carry;
      stage1    = {1'b0, acc} + (lo_fix ? (DATA_W+1)'(8'h06) : '0);
      hi_fix    = stage1[DATA_W] || (stage1[DATA_W-1:NIB] > BCD_MAX) || carry_in;
      result    = stage1[DATA_W-1:0] + (hi_fix ? DATA_W'(8'h60) : '0);
      carry_out = hi_fix;
   end

   // R7: a set carry always forces the high correction
   always_comb begin
      if (carry_in) p_carry_forces_r7: assert (carry_out);
   end
endmodule

// File: rtl/acc_eu_status.sv
module acc_eu_status (
   input  logic clk,
   input  logic rst_n,
   input  logic z_we,
   input  logic z_val,
   input  logic c_we,
   input  logic c_val,
   input  logic wdt_restart,
   input  logic timeout_ev,
   input  logic sleep_ev,
   output logic z_o,
   output logic c_o,
   output logic to_o,
   output logic pd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_o  <= 1'b0;
         c_o  <= 1'b0;
         to_o <= 1'b1;
         pd_o <= 1'b1;
      end else begin
         if (z_we) z_o <= z_val;
         if (c_we) c_o <= c_val;
         if (wdt_restart) begin
            to_o <= 1'b1;
            pd_o <= 1'b1;
         end else begin
            if (timeout_ev) to_o <= 1'b0;
            if (sleep_ev)   pd_o <= 1'b0;
         end
      end
   end

   // R8: a restart leaves both watchdog flags set
   p_restart_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_restart |=> to_o && pd_o);
   // R9: a time-out without a restart clears TO
   p_timeout_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_ev && !wdt_restart) |=> !to_o);
   // R9: a sleep event without a restart clears PD
   p_sleep_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_ev && !wdt_restart) |=> !pd_o);
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
   import acc_eu_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dest_i,
   input  logic              half_carry_i,
   input  logic              psc_to_wdt_i,
   input  logic              wdt_timeout_i,
   input  logic              sleep_i,
   input  logic [ADDR_W-1:0] peek_addr_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] peek_data_o,
   output logic              z_o,
   output logic              c_o,
   output logic              to_o,
   output logic              pd_o,
   output logic              wdt_clr_o,
   output logic              psc_clr_o
);
   logic do_clra, do_clrr, do_comr, do_daa, do_wdt;
   logic [DATA_W-1:0] src, inv, daa_res;
   logic              daa_c;
   logic              rf_we;
   logic [DATA_W-1:0] rf_wdata;

   always_comb begin
      do_clra = exec_i && (op_i == OP_CLRA);
      do_clrr = exec_i && (op_i == OP_CLRR);
      do_comr = exec_i && (op_i == OP_COMR);
      do_daa  = exec_i && (op_i == OP_DAA);
      do_wdt  = exec_i && (op_i == OP_CLRWDT);
   end

   assign inv      = ~src;
   assign rf_we    = do_clrr || (do_comr && dest_i);
   assign rf_wdata = do_clrr ? '0 : inv;

   acc_eu_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .waddr(addr_i), .wdata(rf_wdata),
      .raddr_a(addr_i), .rdata_a(src),
      .raddr_b(peek_addr_i), .rdata_b(peek_data_o)
   );

   acc_eu_decadj #(.DATA_W(DATA_W)) u_daa (
      .acc(acc_o), .half_carry(half_carry_i), .carry_in(c_o),
      .result(daa_res), .carry_out(daa_c)
   );

   acc_eu_status u_st (
      .clk(clk), .rst_n(rst_n),
      .z_we(do_clra || do_clrr || do_comr),
      .z_val(do_comr ? (inv == '0) : 1'b1),
      .c_we(do_daa), .c_val(daa_c),
      .wdt_restart(do_wdt),
      .timeout_ev(wdt_timeout_i), .sleep_ev(sleep_i),
      .z_o(z_o), .c_o(c_o), .to_o(to_o), .pd_o(pd_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o     <= '0;
         wdt_clr_o <= 1'b0;
         psc_clr_o <= 1'b0;
      end else begin
         wdt_clr_o <= do_wdt;
         psc_clr_o <= do_wdt && psc_to_wdt_i;
         if (do_clra)                  acc_o <= '0;
         else if (do_comr && !dest_i)  acc_o <= inv;
         else if (do_daa)              acc_o <= daa_res;
      end
   end

   // R2: zeroing the accumulator leaves 00h and Z set
   p_clra_r2: assert property (@(posedge clk) disable iff (!rst_n)
      do_clra |=> (acc_o == '0) && z_o);
   // R4: inversion to the accumulator holds the inverse of the source read
   p_comr_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_comr && !dest_i) |=> acc_o == ~$past(src));
   // R5: write-back inversion keeps the accumulator
   p_comr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (do_comr && dest_i) |=> $stable(acc_o));
   // R7: decimal adjust never touches Z
   p_daa_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
      do_daa |=> $stable(z_o));
   // R8: prescaler pulse only alongside a watchdog pulse
   p_psc_with_wdt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      psc_clr_o |-> wdt_clr_o);
   // R8: a watchdog pulse only follows a restart strobe
   p_wdt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr_o |-> $past(exec_i && op_i == OP_CLRWDT));
   // R10: no strobe leaves accumulator, Z and C alone
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(acc_o) && $stable(z_o) && $stable(c_o));
endmodule

// File: tb/acc_exec_unit_bench.sv
`timescale 1ns/1ps
module acc_exec_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       exec_i = 0, dest_i = 0, hc_i = 0, psa_i = 0, tmo_i = 0, slp_i = 0;
   logic [2:0] op_i = 0;
   logic [5:0] addr_i = 0, peek_i = 0;
   logic [7:0] acc_o, peek_o;
   logic       z_o, c_o, to_o, pd_o, wdt_o, psc_o;

   acc_exec_unit u_acc_exec_unit (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .addr_i(addr_i),
      .dest_i(dest_i), .half_carry_i(hc_i), .psc_to_wdt_i(psa_i),
      .wdt_timeout_i(tmo_i), .sleep_i(slp_i), .peek_addr_i(peek_i),
      .acc_o(acc_o), .peek_data_o(peek_o), .z_o(z_o), .c_o(c_o),
      .to_o(to_o), .pd_o(pd_o), .wdt_clr_o(wdt_o), .psc_clr_o(psc_o));

   typedef struct {
      string      tag;
      logic [7:0] acc, peek;
      logic       z, c, to, pd, wdt, psc;
   } exp_t;
   exp_t q[$];

   int checks = 0, errors = 0;
   logic [7:0] m_rf [64];
   logic [7:0] m_acc;
   logic       m_z, m_c, m_to, m_pd;
   bit         mon_on = 0;

   task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 64; i++) m_rf[i] = 8'h00;
      m_acc = 0; m_z = 0; m_c = 0; m_to = 1; m_pd = 1;
   endtask

   // driver: presents one cycle of stimulus and queues the expected outcome
   task automatic drive(string tag, bit ex, logic [2:0] op, logic [5:0] a, bit d,
                        bit hc, bit psa, bit tmo, bit slp, logic [5:0] pk);
      exp_t e;
      logic [8:0] t;
      bit lo, hi, wdt;
      @(negedge clk);
      exec_i = ex; op_i = op; addr_i = a; dest_i = d; hc_i = hc;
      psa_i = psa; tmo_i = tmo; slp_i = slp; peek_i = pk;
      wdt = 0;
      if (ex) begin
         case (op)
            3'd1: begin m_acc = 0; m_z = 1; end
            3'd2: begin m_rf[a] = 0; m_z = 1; end
            3'd3: begin
               if (d) m_rf[a] = ~m_rf[a]; else m_acc = ~m_rf[a];
               m_z = ((d ? m_rf[a] : m_acc) == 8'h00);
            end
            3'd4: begin
               lo = (m_acc[3:0] > 4'd9) || hc;
               t  = {1'b0, m_acc} + (lo ? 9'd6 : 9'd0);
               hi = t[8] || (t[7:4] > 4'd9) || m_c;
               m_acc = t[7:0] + (hi ? 8'h60 : 8'h00);
               m_c = hi;
            end
            3'd5: wdt = 1;
            default: ;
         endcase
      end
      if (wdt) begin m_to = 1; m_pd = 1; end
      else begin
         if (tmo) m_to = 0;
         if (slp) m_pd = 0;
      end
      e.tag = tag; e.acc = m_acc; e.peek = m_rf[pk];
      e.z = m_z; e.c = m_c; e.to = m_to; e.pd = m_pd;
      e.wdt = wdt; e.psc = wdt && psa;
      q.push_back(e);
   endtask

   // monitor: one expected item per clock edge, sampled 1 ns after the edge
   always @(posedge clk) begin
      if (mon_on && q.size() > 0) begin
         exp_t e;
         #1;
         e = q.pop_front();
         cmp(e.tag, "acc",  acc_o,  e.acc);
         cmp(e.tag, "peek", peek_o, e.peek);
         cmp(e.tag, "flags", {4'h0, z_o, c_o, to_o, pd_o}, {4'h0, e.z, e.c, e.to, e.pd});
         cmp(e.tag, "pulses", {6'h0, wdt_o, psc_o}, {6'h0, e.wdt, e.psc});
      end
   end

   initial begin
      #500000;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      cmp("R1", "acc", acc_o, 8'h00);
      cmp("R1", "flags", {4'h0, z_o, c_o, to_o, pd_o, wdt_o, psc_o} , 8'h0C);
      for (int i = 0; i < 64; i += 21) begin
         peek_i = 6'(i); #0.5;
         cmp("R1", "reg", peek_o, 8'h00);
      end
      @(negedge clk); rst_n = 1;
      mon_on = 1;
      drive("R5 comr r5 to reg", 1, 3'd3, 6'd5, 1, 0, 0, 0, 0, 6'd5);
      drive("R3 neighbour r4",   0, 3'd0, 6'd0, 0, 0, 0, 0, 0, 6'd4);
      drive("R4 comr r5 to acc", 1, 3'd3, 6'd5, 0, 0, 0, 0, 0, 6'd5);
      drive("R4 comr r0 to acc", 1, 3'd3, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R6 R7 daa FF",      1, 3'd4, 6'd0, 0, 0, 0, 0, 0, 6'd5);
      drive("R7 daa carry set",  1, 3'd4, 6'd0, 0, 0, 0, 0, 0, 6'd5);
      drive("R7 daa high nib",   1, 3'd4, 6'd0, 0, 1, 0, 0, 0, 6'd5);
      drive("R3 clrr r5",        1, 3'd2, 6'd5, 0, 0, 0, 0, 0, 6'd5);
      drive("R5 comr r63",       1, 3'd3, 6'd63, 1, 0, 0, 0, 0, 6'd63);
      drive("R3 clrr r63",       1, 3'd2, 6'd63, 0, 0, 0, 0, 0, 6'd63);
      drive("R2 clra",           1, 3'd1, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R7 daa forced",     1, 3'd4, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R10 no strobe",     0, 3'd1, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R10 op 6",          1, 3'd6, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R10 op 7",          1, 3'd7, 6'd9, 1, 0, 0, 0, 0, 6'd9);
      drive("R10 op 0",          1, 3'd0, 6'd9, 1, 0, 0, 0, 0, 6'd9);
      drive("R9 timeout",        0, 3'd0, 6'd0, 0, 0, 0, 1, 0, 6'd0);
      drive("R9 sleep",          0, 3'd0, 6'd0, 0, 0, 0, 0, 1, 6'd0);
      drive("R8 clrwdt psa0",    1, 3'd5, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R11 pulse ends",    0, 3'd0, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      drive("R8 clrwdt psa1",    1, 3'd5, 6'd0, 0, 0, 1, 0, 0, 6'd0);
      drive("R9 clrwdt wins",    1, 3'd5, 6'd0, 0, 0, 1, 1, 1, 6'd0);
      drive("R9 both events",    0, 3'd0, 6'd0, 0, 0, 1, 1, 1, 6'd0);
      for (int i = 0; i < 64; i += 3)
         drive("R5 sweep", 1, 3'd3, 6'(i), 1, 0, 0, 0, 0, 6'(i));
      for (int i = 0; i < 64; i += 7)
         drive("R3 sweep peek", 0, 3'd0, 6'd0, 0, 0, 0, 0, 0, 6'(i));
      drive("R4 comr zero z",    1, 3'd3, 6'd1, 0, 0, 0, 0, 0, 6'd1);
      drive("R4 comr ff",        1, 3'd3, 6'd3, 0, 0, 0, 0, 0, 6'd3);
      drive("R6 daa low hc",     1, 3'd4, 6'd0, 0, 1, 0, 0, 0, 6'd0);
      drive("R11 idle",          0, 3'd0, 6'd0, 0, 0, 0, 0, 0, 6'd0);
      @(negedge clk); exec_i = 0;
      repeat (2) @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule